// File: doc/BRIEF.md
# Serial Command Front-End with Parity

This block is the slave side of a serial command port for a small storage device. The host frames each transaction with chip select and shifts bits in on the serial clock. A transaction is an 8-bit command code, then for some commands an address and a data word. The block decodes the command and acts on a small register array that stands in for a nonvolatile array. A write or an erase starts an internal cycle that a programmable counter times. While that cycle runs, the host can ask for a status byte. Once it has enabled ready/busy signalling, it can instead watch the data line after a write for a busy level and then a ready level.

A static parity-select input chooses between plain frames and frames in which each field carries one trailing even-parity bit. A parity mismatch or an unknown command code sets a sticky error. The error is shown on an open-drain style output, the block then ignores the rest of the frame, and the data output stays released until chip select is taken low. Both pad outputs are given as level-plus-enable pairs, so that the pad ring supplies the actual high-impedance drivers and the pull-down on the parity-select pin.

The state machine has nine states. ST_OPCODE collects the command code. ST_OPC_PAR checks its parity bit. ST_ADDR and ST_ADDR_PAR do the same for the address, and ST_DATA and ST_DATA_PAR for the data. ST_SHIFT_OUT sends read data or status. ST_RDY_BUSY shows the internal cycle on the data line. ST_HOLD waits out the rest of a frame. The transitions are as follows:
- A rising edge with chip select low returns the machine to ST_OPCODE.
- A field's last bit moves it to that field's parity state when parity is selected, and otherwise straight to the action.
- A command decode moves it to ST_ADDR, ST_SHIFT_OUT (status) or ST_HOLD.
- An address completion moves it to ST_SHIFT_OUT (read), ST_DATA (write) or ST_RDY_BUSY (erase).
- A data completion moves it to ST_RDY_BUSY.
- Any error or ignored command moves it to ST_HOLD.
- ST_SHIFT_OUT returns to ST_HOLD after its last bit.

Top module: `sercmd_frontend`

## Requirements
- R1: Sampling and framing:
  - Input bits are sampled on rising clock edges while chip select is high.
  - A frame starts at the first rising edge with chip select high after an edge with it low.
  - The command code comes first, most significant bit first. Then come ADDR_W address bits and then DATA_W data bits, each field most significant bit first.
  - The command codes are: read 0x03, write 0x02, status 0x05, ready/busy enable 0x0B and erase 0x0C.
- R2: With `par_en` high, each field (command, address, data) is followed by one bit that makes the count of ones in the field plus that bit even. A mismatch sets the error. With `par_en` low, no parity bits are taken.
- R3: Any command code other than the five listed in R1 sets the error when the code is complete.
- R4: The error handling:
  - While the error is set, `err_low` is 1 and it stays 1 while chip select remains high.
  - The first rising edge with chip select low clears it.
  - The rest of an errored frame has no effect on the array.
- R5: `sdo_oe` is 0 in all of these cases: after reset, whenever chip select is low, while the error is set, and outside the read, status and ready/busy output phases.
- R6: Read: after the last address bit (or its parity bit), the addressed word is driven on `sdo` most significant bit first. Each bit changes on a falling edge and is valid for the following rising edge. Output is then released.
- R7: Write stores the data word at the address. Erase sets every bit of the addressed word to 1. Either one starts an internal cycle that is busy for exactly BUSY_CYCLES rising edges after the completing edge.
- R8: While the internal cycle is busy, read, write, erase and ready/busy-enable frames are ignored: no array change and `sdo_oe` stays 0.
- R9: Status during a busy cycle returns 8 bits, most significant bit first. Bit 7 is 1, bit 6 is the ready/busy-enable flag and bits 5..0 are 0. A status frame when not busy leaves `sdo_oe` at 0.
- R10: After a ready/busy-enable frame (cleared only by reset), a completed write or erase frame in which chip select stays high drives `sdo` to 0 while busy and to 1 once ready. Without the enable, the data line stays released in that phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, high selects; low ends the frame and clears the error |
| sdi | input | 1 | Serial data in, sampled on rising edges |
| par_en | input | 1 | Even-parity select; pad pull-down makes the default 0 |
| sdo | output | 1 | Serial data out level, changes on falling edges |
| sdo_oe | output | 1 | Output enable for the data pad driver |
| err_low | output | 1 | 1 = pull the open-drain error line low |

## Verification
The bench targets these corner cases:
- Parity bits that are wrong in each of the three fields, each of which must abort the frame without touching the array. A design that checked only the command, or counted odd parity, would either store corrupted data or flag good frames.
- A status request and a write issued during a busy cycle. A design that failed to gate commands on busy would overwrite the word, and one that ignored status would leave the line released.
- The ready/busy phase and an illegal code followed by further frame bits. A misplaced busy count shows a ready level one edge early or late, and a non-sticky error would let the tail of the frame act.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_STAT  = 8'h05;
    localparam logic [7:0] OPC_RBEN  = 8'h0B;
    localparam logic [7:0] OPC_ERASE = 8'h0C;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_OPC_PAR,
        ST_ADDR,
        ST_ADDR_PAR,
        ST_DATA,
        ST_DATA_PAR,
        ST_SHIFT_OUT,
        ST_RDY_BUSY,
        ST_HOLD
    } fe_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_STAT,
        CMD_RBEN,
        CMD_ERASE
    } fe_cmd_t;

    function automatic fe_cmd_t decode_cmd(input logic [7:0] code);
        fe_cmd_t c;
        unique case (code)
            OPC_READ:  c = CMD_READ;
            OPC_WRITE: c = CMD_WRITE;
            OPC_STAT:  c = CMD_STAT;
            OPC_RBEN:  c = CMD_RBEN;
            OPC_ERASE: c = CMD_ERASE;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfe_busy_timer.sv
module sfe_busy_timer #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= BW'(BUSY_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - BW'(1);
        end
    end

    assign busy_o = (remain != '0);

    // R7: a started cycle is busy on the following edge
    assert_busy_follows_start_R7: assert property (
        @(posedge clk) disable iff (!rst_n) start_i |=> busy_o);

endmodule

// File: rtl/sfe_cell_array.sv
module sfe_cell_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (we_i && (waddr_i == ADDR_W'(g))) begin
                cells[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/sfe_out_stage.sv
module sfe_out_stage #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OUT_W-1:0] word_i,
    input  logic             advance_i,
    input  logic             send_i,
    input  logic             rb_i,
    input  logic             ready_i,
    output logic             oe_o,
    output logic             bit_o
);
    logic [OUT_W-1:0] obuf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf <= '0;
        end else if (load_i) begin
            obuf <= word_i;
        end else if (advance_i) begin
            obuf <= {obuf[OUT_W-2:0], 1'b0};
        end
    end

    // output pins move on the falling edge, half a period ahead of sampling
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_o  <= 1'b0;
            bit_o <= 1'b0;
        end else begin
            oe_o  <= send_i | rb_i;
            bit_o <= send_i ? obuf[OUT_W-1] : ready_i;
        end
    end

endmodule

// File: rtl/sercmd_frontend.sv
module sercmd_frontend
    import sfe_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sdi,
    input  logic par_en,
    output logic sdo,
    output logic sdo_oe,
    output logic err_low
);
    localparam int OUT_W = (DATA_W > 8) ? DATA_W : 8;
    localparam int SH_W  = (ADDR_W > OUT_W) ? ADDR_W : OUT_W;
    localparam int CNT_W = $clog2(SH_W + 1);

    fe_state_t         state, state_n;
    fe_cmd_t           cmd_q, cmd_n, cmd_dec;
    logic [CNT_W-1:0]  cnt, cnt_n, olen_q, olen_n;
    logic [SH_W-1:0]   shreg, sh_next;
    logic [ADDR_W-1:0] addr_q, addr_n, addr_sel, wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data, data_sel;
    logic [OUT_W-1:0]  out_word;
    logic [7:0]        op_val;
    logic              err_q, rb_en_q, busy;
    logic              set_err, rb_set, mem_we, busy_start, out_load, out_adv;
    logic              act_opc, act_addr, act_data, shift_en;
    logic              we_g, start_g, load_g, oe_raw, bit_raw;

    assign sh_next  = {shreg[SH_W-2:0], sdi};
    assign shift_en = (state == ST_OPCODE) || (state == ST_ADDR) || (state == ST_DATA);
    assign op_val   = (state == ST_OPCODE) ? sh_next[7:0] : shreg[7:0];
    assign cmd_dec  = decode_cmd(op_val);
    assign addr_sel = (state == ST_ADDR) ? sh_next[ADDR_W-1:0] : addr_q;
    assign data_sel = (state == ST_DATA) ? sh_next[DATA_W-1:0] : shreg[DATA_W-1:0];

    always_comb begin
        state_n    = state;
        cnt_n      = cnt + CNT_W'(1);
        cmd_n      = cmd_q;
        addr_n     = addr_q;
        olen_n     = olen_q;
        set_err    = 1'b0;
        rb_set     = 1'b0;
        mem_we     = 1'b0;
        busy_start = 1'b0;
        out_load   = 1'b0;
        out_adv    = 1'b0;
        out_word   = '0;
        wr_addr    = addr_q;
        wr_data    = '0;
        act_opc    = 1'b0;
        act_addr   = 1'b0;
        act_data   = 1'b0;

        unique case (state)
            ST_OPCODE: begin
                if (cnt == CNT_W'(7)) begin
                    if (par_en) state_n = ST_OPC_PAR;
                    else        act_opc = 1'b1;
                end
            end
            ST_OPC_PAR: begin
                if (^shreg[7:0] ^ sdi) set_err = 1'b1;
                else                   act_opc = 1'b1;
            end
            ST_ADDR: begin
                if (cnt == CNT_W'(ADDR_W - 1)) begin
                    addr_n = sh_next[ADDR_W-1:0];
                    if (par_en) state_n  = ST_ADDR_PAR;
                    else        act_addr = 1'b1;
                end
            end
            ST_ADDR_PAR: begin
                if (^addr_q ^ sdi) set_err  = 1'b1;
                else               act_addr = 1'b1;
            end
            ST_DATA: begin
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    if (par_en) state_n  = ST_DATA_PAR;
                    else        act_data = 1'b1;
                end
            end
            ST_DATA_PAR: begin
                if (^shreg[DATA_W-1:0] ^ sdi) set_err  = 1'b1;
                else                          act_data = 1'b1;
            end
            ST_SHIFT_OUT: begin
                out_adv = 1'b1;
                if (cnt == olen_q - CNT_W'(1)) state_n = ST_HOLD;
            end
            ST_RDY_BUSY, ST_HOLD: cnt_n = cnt;
        endcase

        if (act_opc) begin
            cmd_n = cmd_dec;
            unique case (cmd_dec)
                CMD_NONE: set_err = 1'b1;
                CMD_STAT: begin
                    if (busy) begin
                        out_load = 1'b1;
                        out_word = OUT_W'({1'b1, rb_en_q, 6'b0}) << (OUT_W - 8);
                        olen_n   = CNT_W'(8);
                        state_n  = ST_SHIFT_OUT;
                    end else begin
                        state_n  = ST_HOLD;
                    end
                end
                CMD_RBEN: begin
                    rb_set  = !busy;
                    state_n = ST_HOLD;
                end
                default: state_n = busy ? ST_HOLD : ST_ADDR;
            endcase
        end

        if (act_addr) begin
            unique case (cmd_q)
                CMD_READ: begin
                    out_load = 1'b1;
                    out_word = OUT_W'(rd_data) << (OUT_W - DATA_W);
                    olen_n   = CNT_W'(DATA_W);
                    state_n  = ST_SHIFT_OUT;
                end
                CMD_WRITE: state_n = ST_DATA;
                CMD_ERASE: begin
                    mem_we     = 1'b1;
                    wr_addr    = addr_sel;
                    wr_data    = '1;
                    busy_start = 1'b1;
                    state_n    = ST_RDY_BUSY;
                end
                default: state_n = ST_HOLD;
            endcase
        end

        if (act_data) begin
            mem_we     = 1'b1;
            wr_data    = data_sel;
            busy_start = 1'b1;
            state_n    = ST_RDY_BUSY;
        end

        if (set_err) state_n = ST_HOLD;
        if (state_n != state) cnt_n = '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_OPCODE;
        else if (!cs) state <= ST_OPCODE;
        else          state <= state_n;
    end

    // frame datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cmd_q   <= CMD_NONE;
            addr_q  <= '0;
            olen_q  <= '0;
            shreg   <= '0;
            err_q   <= 1'b0;
            rb_en_q <= 1'b0;
        end else if (!cs) begin
            cnt   <= '0;
            err_q <= 1'b0;
        end else begin
            cnt    <= cnt_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            olen_q <= olen_n;
            if (shift_en) shreg   <= sh_next;
            if (set_err)  err_q   <= 1'b1;
            if (rb_set)   rb_en_q <= 1'b1;
        end
    end

    assign we_g    = mem_we & cs;
    assign start_g = busy_start & cs;
    assign load_g  = out_load & cs;

    sfe_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .we_i(we_g), .waddr_i(wr_addr),
        .wdata_i(wr_data), .raddr_i(addr_sel), .rdata_o(rd_data)
    );

    sfe_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_g), .busy_o(busy)
    );

    sfe_out_stage #(.OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load_i(load_g), .word_i(out_word),
        .advance_i(out_adv), .send_i(state == ST_SHIFT_OUT),
        .rb_i((state == ST_RDY_BUSY) && rb_en_q), .ready_i(!busy),
        .oe_o(oe_raw), .bit_o(bit_raw)
    );

    assign sdo     = bit_raw;
    assign sdo_oe  = oe_raw & cs & !err_q;
    assign err_low = err_q;

    // R4: an edge with chip select low clears the error
    assert_cs_low_clears_err_R4: assert property (
        @(posedge clk) disable iff (!rst_n) !cs |=> !err_q);

    // R4: the error holds while chip select stays high
    assert_err_sticky_R4: assert property (
        @(posedge clk) disable iff (!rst_n) (err_q && cs) |=> err_q);

    // R8: the array is never written during a busy cycle
    assert_no_store_while_busy_R8: assert property (
        @(posedge clk) disable iff (!rst_n) we_g |-> !busy);

    // R5: no shifting out once an error is latched
    assert_shift_out_clean_R5: assert property (
        @(posedge clk) disable iff (!rst_n) (state == ST_SHIFT_OUT) |-> !err_q);

endmodule

// File: tb/sercmd_frontend_test.sv
module sercmd_frontend_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NB = 40;
    localparam int PH_OP = 0, PH_OPP = 1, PH_AD = 2, PH_ADP = 3, PH_DA = 4,
                   PH_DAP = 5, PH_OUT = 6, PH_RB = 7, PH_HOLD = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sdi = 1'b0, par_en = 1'b0;
    logic sdo, sdo_oe, err_low;

    always #10 clk = ~clk;

    sercmd_frontend #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .par_en(par_en),
        .sdo(sdo), .sdo_oe(sdo_oe), .err_low(err_low)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R5";

    // behavioural reference model
    int  m_phase = PH_OP, m_cnt = 0, m_acc = 0, m_op = 0, m_addr = 0, m_busy = 0;
    bit  m_err = 0, m_rb = 0, m_start = 0, exp_oe = 0, exp_bit = 0;
    int  mem [16];
    bit  outq [$];

    task automatic report(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic m_bad();
        m_err = 1; m_phase = PH_HOLD;
    endtask

    task automatic m_opcode(bit was_busy);
        if (!(m_op inside {2, 3, 5, 11, 12})) m_bad();
        else if (m_op == 5) begin
            if (was_busy) begin
                outq = {1'b1, m_rb, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
                m_phase = PH_OUT;
            end else m_phase = PH_HOLD;
        end else if (was_busy) m_phase = PH_HOLD;
        else if (m_op == 11) begin m_rb = 1; m_phase = PH_HOLD; end
        else begin m_phase = PH_AD; m_cnt = 0; m_acc = 0; end
    endtask

    task automatic m_address();
        if (m_op == 3) begin
            outq.delete();
            for (int i = DW - 1; i >= 0; i--) outq.push_back(mem[m_addr][i]);
            m_phase = PH_OUT;
        end else if (m_op == 2) begin
            m_phase = PH_DA; m_cnt = 0; m_acc = 0;
        end else begin
            mem[m_addr] = 255; m_start = 1; m_phase = PH_RB;
        end
    endtask

    task automatic m_store(int v);
        mem[m_addr] = v; m_start = 1; m_phase = PH_RB;
    endtask

    int m_dval = 0;

    task automatic model_edge(bit c, bit d);
        bit was_busy = (m_busy > 0);
        m_start = 0;
        if (!c) begin
            m_err = 0; m_phase = PH_OP; m_cnt = 0; m_acc = 0; outq.delete();
        end else if (!m_err) begin
            case (m_phase)
                PH_OP: begin
                    m_acc = (m_acc << 1) | d; m_cnt++;
                    if (m_cnt == 8) begin
                        m_op = m_acc & 255; m_acc = 0; m_cnt = 0;
                        if (par_en) m_phase = PH_OPP; else m_opcode(was_busy);
                    end
                end
                PH_OPP: if ((($countones(8'(m_op)) + d) % 2) != 0) m_bad(); else m_opcode(was_busy);
                PH_AD: begin
                    m_acc = (m_acc << 1) | d; m_cnt++;
                    if (m_cnt == AW) begin
                        m_addr = m_acc; m_acc = 0; m_cnt = 0;
                        if (par_en) m_phase = PH_ADP; else m_address();
                    end
                end
                PH_ADP: if ((($countones(4'(m_addr)) + d) % 2) != 0) m_bad(); else m_address();
                PH_DA: begin
                    m_acc = (m_acc << 1) | d; m_cnt++;
                    if (m_cnt == DW) begin
                        m_dval = m_acc; m_acc = 0; m_cnt = 0;
                        if (par_en) m_phase = PH_DAP; else m_store(m_dval);
                    end
                end
                PH_DAP: if ((($countones(8'(m_dval)) + d) % 2) != 0) m_bad(); else m_store(m_dval);
                PH_OUT: begin
                    void'(outq.pop_front());
                    if (outq.size() == 0) m_phase = PH_HOLD;
                end
                default: ;
            endcase
        end
        if (m_start) m_busy = NB;
        else if (m_busy > 0) m_busy--;
        exp_oe  = c && !m_err && ((m_phase == PH_OUT) || (m_phase == PH_RB && m_rb));
        exp_bit = (m_phase == PH_OUT) ? outq[0] : (m_busy == 0);
    endtask

    task automatic cyc(bit d, bit c);
        sdi = d; cs = c;
        @(posedge clk);
        model_edge(c, d);
        @(negedge clk);
        #5;
        report("err_low", int'(err_low), int'(m_err));
        report("sdo_oe", int'(sdo_oe), int'(exp_oe));
        if (exp_oe) report("sdo", int'(sdo), int'(exp_bit));
    endtask

    task automatic frame(logic [7:0] op, bit ha, logic [3:0] a, bit hd,
                         logic [7:0] dv, int extra, int badmask);
        for (int i = 7; i >= 0; i--) cyc(op[i], 1'b1);
        if (par_en) cyc((^op) ^ badmask[0], 1'b1);
        if (ha) begin
            for (int i = AW - 1; i >= 0; i--) cyc(a[i], 1'b1);
            if (par_en) cyc((^a) ^ badmask[1], 1'b1);
        end
        if (hd) begin
            for (int i = DW - 1; i >= 0; i--) cyc(dv[i], 1'b1);
            if (par_en) cyc((^dv) ^ badmask[2], 1'b1);
        end
        for (int i = 0; i < extra; i++) cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 0;
        repeat (3) @(negedge clk);
        #5;
        cur_req = "R5";
        report("reset err_low", int'(err_low), 0);
        report("reset sdo_oe", int'(sdo_oe), 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R1";   frame(8'h02, 1, 4'd5, 1, 8'hA5, NB + 3, 0);
        cur_req = "R6";   frame(8'h03, 1, 4'd5, 0, 8'h00, 10, 0);
        cur_req = "R7";   frame(8'h0C, 1, 4'd9, 0, 8'h00, NB + 3, 0);
                          frame(8'h03, 1, 4'd9, 0, 8'h00, 10, 0);
        cur_req = "R3";   frame(8'hFF, 1, 4'd5, 1, 8'h00, 6, 0);
        cur_req = "R4";   frame(8'h03, 1, 4'd5, 0, 8'h00, 10, 0);
        cur_req = "R10";  frame(8'h0B, 0, 4'd0, 0, 8'h00, 2, 0);
                          frame(8'h02, 1, 4'd2, 1, 8'h3C, NB + 3, 0);
        cur_req = "R9";   frame(8'h02, 1, 4'd1, 1, 8'h66, 0, 0);
                          frame(8'h05, 0, 4'd0, 0, 8'h00, 9, 0);
        cur_req = "R8";   frame(8'h02, 1, 4'd1, 1, 8'h00, 0, 0);
                          idle(NB);
                          frame(8'h03, 1, 4'd1, 0, 8'h00, 10, 0);
        cur_req = "R9";   frame(8'h05, 0, 4'd0, 0, 8'h00, 9, 0);

        par_en = 1'b1;
        cur_req = "R2";   frame(8'h02, 1, 4'd7, 1, 8'h81, NB + 3, 0);
                          frame(8'h03, 1, 4'd7, 0, 8'h00, 10, 0);
                          frame(8'h03, 1, 4'd7, 0, 8'h00, 10, 1);
                          frame(8'h02, 1, 4'd7, 1, 8'h18, NB + 3, 2);
                          frame(8'h02, 1, 4'd7, 1, 8'h18, NB + 3, 4);
                          frame(8'h03, 1, 4'd7, 0, 8'h00, 10, 0);
        cur_req = "R3";   frame(8'h55, 1, 4'd7, 1, 8'h00, 20, 0);
        par_en = 1'b0;
        cur_req = "R5";   idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule